// File: doc/BRIEF.md
# Filtered External Interrupt Level Decoder

This block turns a four-bit, active-low coded external interrupt level bus into a priority level and a request flag for a CPU interrupt controller. The pins are sampled on single-cycle enable pulses. In normal operation the pulses come from the peripheral clock domain. In standby they come from a slow real-time clock tick. A code reaches the decoded level only after two consecutive samples have returned the same value, so a glitch that lasts for a single sample is never seen.

The decoded level is 15 minus the pin code. A request is raised when that level is strictly above the 4-bit mask taken from the status register. The block only reads the mask and never changes it. A small state machine tracks the request through three states: `ST_IDLE` (nothing pending), `ST_PEND` (request raised, not yet accepted) and `ST_TAKEN` (accepted, waiting for the level to rise or fall). Its transitions are:
- `ST_IDLE -> ST_PEND` when level > mask.
- `ST_PEND -> ST_TAKEN` on accept.
- `ST_PEND -> ST_IDLE` when level <= mask.
- `ST_TAKEN -> ST_PEND` when level > mask and level > the accepted level.
- `ST_TAKEN -> ST_IDLE` when level <= mask.

If the level falls while a request is pending and not yet accepted, the block flags a protocol error.

Top module: `irq_level_filter`

## Requirements
- R1: The decoded level `irq_level` equals 15 minus the filtered pin code. Code 4'b0000 gives level 15, and code 4'b1111 gives level 0, which means no request.
- R2: On a sample pulse, the pin code is taken as the filtered code only if it equals the code seen at the previous sample pulse. A code seen at only one sample leaves `irq_level` unchanged.
- R3: With `standby` low, only `pclk_en` pulses sample the pins. `rtc_tick` has no effect.
- R4: With `standby` high, only `rtc_tick` pulses sample the pins. `pclk_en` has no effect, and with no ticks the level stays frozen.
- R5: `irq_pending` is high in the cycle after `irq_level > sr_mask` holds, under the strict comparison (equal is not enough). This applies while no accept has been taken.
- R6: `accept` while `irq_pending` is high loads `acc_level` with the current `irq_level` and drops `irq_pending` on the next cycle. `accept` while `irq_pending` is low changes nothing.
- R7: After an accept, `irq_pending` rises again only once the level exceeds both `acc_level` and `sr_mask`.
- R8: `lower_err` pulses for one cycle, the cycle after an update that lowers `irq_level` while `irq_pending` is high.
- R9: After reset, both the sample register and the filtered code hold 4'b1111. The outputs are then `irq_level`=0, `irq_pending`=0, `acc_level`=0 and `lower_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_pins | input | 4 | Active-low coded external level bus |
| pclk_en | input | 1 | Sample pulse from the peripheral clock domain |
| rtc_tick | input | 1 | Sample pulse from the real-time clock (standby) |
| standby | input | 1 | Selects the real-time clock tick as the sample source |
| sr_mask | input | 4 | Interrupt mask level from the status register (read only) |
| accept | input | 1 | One-cycle acknowledge of the pending request |
| irq_level | output | 4 | Filtered priority level |
| irq_pending | output | 1 | Request raised and not yet accepted |
| acc_level | output | 4 | Level captured at the last accept |
| lower_err | output | 1 | Level dropped while a request was pending |

## Verification
The bench sends a one-sample glitch between stable codes. A filter that took every sample would let the level jump.

It sets the level equal to the mask to catch a non-strict comparison. It pulses accept both while a request is pending and while none is, to catch an accept that is not qualified by the pending state. It lowers the level while a request is pending to catch a missing or sticky error pulse.

Finally, it swaps sample sources in and out of standby. A design with a wrong enable mux would then track pins it should ignore, or freeze in normal mode.

// File: rtl/ilf_pkg.sv
package ilf_pkg;
    localparam int LVL_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_TAKEN = 2'd2
    } ilf_state_e;
endpackage

// File: rtl/ilf_sampler.sv
module ilf_sampler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         pclk_en,
    input  logic         rtc_tick,
    input  logic [W-1:0] pins,
    output logic [W-1:0] code_q,
    output logic [W-1:0] code_nxt
);
    localparam logic [W-1:0] IDLE_CODE = {W{1'b1}};

    logic         samp_en;
    logic [W-1:0] smp_q;

    // Only the source chosen by standby can open a sample slot
    assign samp_en  = standby ? rtc_tick : pclk_en;
    assign code_nxt = (samp_en && (pins == smp_q)) ? pins : code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q  <= IDLE_CODE;
            code_q <= IDLE_CODE;
        end else begin
            if (samp_en) smp_q <= pins;
            code_q <= code_nxt;
        end
    end
endmodule

// File: rtl/ilf_decode.sv
module ilf_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] code_q,
    input  logic [W-1:0] code_nxt,
    input  logic [W-1:0] mask,
    output logic [W-1:0] level,
    output logic         above_mask,
    output logic         dropping
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] level_nxt;

    assign level      = TOP - code_q;
    assign level_nxt  = TOP - code_nxt;
    assign above_mask = level > mask;
    assign dropping   = level_nxt < level;
endmodule

// File: rtl/ilf_req_fsm.sv
module ilf_req_fsm
    import ilf_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic         above_mask,
    input  logic         dropping,
    input  logic         accept,
    output logic         pending,
    output logic [W-1:0] acc_level,
    output logic         lower_err
);
    ilf_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (above_mask) state_d = ST_PEND;
            ST_PEND: begin
                if (accept)           state_d = ST_TAKEN;
                else if (!above_mask) state_d = ST_IDLE;
            end
            ST_TAKEN: begin
                if (!above_mask)             state_d = ST_IDLE;
                else if (level > acc_level)  state_d = ST_PEND;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_level <= '0;
            lower_err <= 1'b0;
        end else begin
            if (state_q == ST_PEND && accept) acc_level <= level;
            lower_err <= (state_q == ST_PEND) && dropping;
        end
    end

    assign pending = (state_q == ST_PEND);
endmodule

// File: rtl/irq_level_filter.sv
module irq_level_filter
    import ilf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_pins,
    input  logic             pclk_en,
    input  logic             rtc_tick,
    input  logic             standby,
    input  logic [LVL_W-1:0] sr_mask,
    input  logic             accept,
    output logic [LVL_W-1:0] irq_level,
    output logic             irq_pending,
    output logic [LVL_W-1:0] acc_level,
    output logic             lower_err
);
    logic [LVL_W-1:0] code_q, code_nxt;
    logic             above_mask, dropping;

    ilf_sampler #(.W(LVL_W)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .standby  (standby),
        .pclk_en  (pclk_en),
        .rtc_tick (rtc_tick),
        .pins     (lvl_pins),
        .code_q   (code_q),
        .code_nxt (code_nxt)
    );

    ilf_decode #(.W(LVL_W)) u_dec (
        .code_q     (code_q),
        .code_nxt   (code_nxt),
        .mask       (sr_mask),
        .level      (irq_level),
        .above_mask (above_mask),
        .dropping   (dropping)
    );

    ilf_req_fsm #(.W(LVL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (irq_level),
        .above_mask (above_mask),
        .dropping   (dropping),
        .accept     (accept),
        .pending    (irq_pending),
        .acc_level  (acc_level),
        .lower_err  (lower_err)
    );
endmodule

// File: rtl/irq_level_filter_chk.sv
module irq_level_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pclk_en,
    input logic       rtc_tick,
    input logic       standby,
    input logic [3:0] sr_mask,
    input logic       accept,
    input logic [3:0] irq_level,
    input logic       irq_pending,
    input logic [3:0] acc_level,
    input logic       lower_err
);
    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby && !pclk_en) |=> $stable(irq_level)); // R3
    AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && !rtc_tick) |=> $stable(irq_level)); // R4
    AST_PEND_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> ($past(irq_level) > $past(sr_mask))); // R5
    AST_ACCEPT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && irq_pending) |=> (!irq_pending && acc_level == $past(irq_level))); // R6
    AST_ACC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && irq_pending) |=> $stable(acc_level)); // R6
    AST_ERR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        lower_err |-> ($past(irq_pending) && irq_level < $past(irq_level))); // R8
endmodule

bind irq_level_filter irq_level_filter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pclk_en     (pclk_en),
    .rtc_tick    (rtc_tick),
    .standby     (standby),
    .sr_mask     (sr_mask),
    .accept      (accept),
    .irq_level   (irq_level),
    .irq_pending (irq_pending),
    .acc_level   (acc_level),
    .lower_err   (lower_err)
);

// File: tb/sim_irq_level_filter.sv
`timescale 1ns/1ps
module sim_irq_level_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] lvl_pins = 4'hF;
    logic       pclk_en = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       standby = 1'b0;
    logic [3:0] sr_mask = 4'h0;
    logic       accept = 1'b0;
    logic [3:0] irq_level;
    logic       irq_pending;
    logic [3:0] acc_level;
    logic       lower_err;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_smp = 15, m_code = 15, m_st = 0, m_acc = 0;
    bit m_err = 0;

    always #10 clk = ~clk;

    irq_level_filter u0 (
        .clk(clk), .rst_n(rst_n), .lvl_pins(lvl_pins), .pclk_en(pclk_en),
        .rtc_tick(rtc_tick), .standby(standby), .sr_mask(sr_mask), .accept(accept),
        .irq_level(irq_level), .irq_pending(irq_pending), .acc_level(acc_level),
        .lower_err(lower_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // behavioural reference, compared on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_smp = 15; m_code = 15; m_st = 0; m_acc = 0; m_err = 0;
        end else begin
            bit en;
            int old_l, new_l, nxt_code;
            en = standby ? rtc_tick : pclk_en;
            old_l = 15 - m_code;
            nxt_code = m_code;
            if (en && int'(lvl_pins) == m_smp) nxt_code = lvl_pins;
            if (en) m_smp = lvl_pins;
            new_l = 15 - nxt_code;
            m_err = (m_st == 1) && (new_l < old_l);
            if (m_st == 0) begin
                if (old_l > sr_mask) m_st = 1;
            end else if (m_st == 1) begin
                if (accept) begin m_st = 2; m_acc = old_l; end
                else if (old_l <= sr_mask) m_st = 0;
            end else begin
                if (old_l <= sr_mask) m_st = 0;
                else if (old_l > m_acc) m_st = 1;
            end
            m_code = nxt_code;
            #2;
            check("R1 level", irq_level, 15 - m_code);
            check("R5 pending", irq_pending, (m_st == 1) ? 1 : 0);
            check("R6 acc_level", acc_level, m_acc);
            check("R8 lower_err", lower_err, m_err);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic smp(input logic [3:0] p, input bit use_rtc);
        @(negedge clk);
        lvl_pins = p;
        if (use_rtc) rtc_tick = 1'b1; else pclk_en = 1'b1;
        @(negedge clk);
        rtc_tick = 1'b0;
        pclk_en  = 1'b0;
    endtask

    task automatic pulse_accept();
        @(negedge clk);
        accept = 1'b1;
        @(negedge clk);
        accept = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R9 reset level", irq_level, 0);
        check("R9 reset pending", irq_pending, 0);
        check("R9 reset acc", acc_level, 0);
        check("R9 reset err", lower_err, 0);

        // one-sample glitch is dropped
        smp(4'h3, 0); smp(4'hF, 0);
        check("R2 glitch ignored", irq_level, 0);
        smp(4'h3, 0); smp(4'h3, 0);
        check("R1 code 3 -> 12", irq_level, 12);
        idle(2);
        check("R5 pending above mask", irq_pending, 1);

        // equal to mask is not enough
        sr_mask = 4'd12; idle(2);
        check("R5 equal mask no pending", irq_pending, 0);
        sr_mask = 4'd11; idle(2);
        check("R5 pending again", irq_pending, 1);

        pulse_accept();
        check("R6 acc captured", acc_level, 12);
        check("R6 pending cleared", irq_pending, 0);
        idle(2);
        check("R7 no re-raise at same level", irq_pending, 0);

        smp(4'h0, 0); smp(4'h0, 0);
        check("R1 all-zero -> 15", irq_level, 15);
        idle(2);
        check("R7 re-raise on higher level", irq_pending, 1);

        // drop while pending
        smp(4'h5, 0); smp(4'h5, 0);
        check("R8 lower_err pulse", lower_err, 1);
        idle(1);
        check("R8 lower_err one cycle", lower_err, 0);
        idle(2);
        check("R5 below mask idle", irq_pending, 0);
        pulse_accept();
        check("R6 accept ignored when idle", acc_level, 12);

        // standby: peripheral enable ignored, tick used
        standby = 1'b1;
        smp(4'h1, 0); smp(4'h1, 0);
        check("R4 pclk ignored in standby", irq_level, 10);
        idle(4);
        check("R4 frozen without ticks", irq_level, 10);
        smp(4'h1, 1); smp(4'h1, 1);
        check("R4 tick samples in standby", irq_level, 14);
        standby = 1'b0;
        smp(4'h7, 1); smp(4'h7, 1);
        check("R3 tick ignored in normal", irq_level, 14);

        smp(4'hF, 0); smp(4'hF, 0);
        check("R1 all-ones -> 0", irq_level, 0);
        idle(3);
        finish_run();
    end
endmodule